// File: doc/BRIEF.md
# Flag-Predicated Instruction Sequencer

This block is the control unit of a small accumulator machine with an 8-bit datapath and a 16-bit program counter. It fetches one instruction byte per cycle from the code bus at the address it drives on `pc`. The upper nibble of each byte is the opcode. The lower nibble selects a condition, and the condition is evaluated directly from the current values of registers A and B. No flag register stands between the compare and the instruction that uses it. Any instruction can therefore be made conditional on a fresh comparison. A conditional register move is suppressed when the selected condition is false. A conditional jump loads the program counter only when its condition is true.

The block turns each byte into registered write strobes for registers A, B and C, a registered write-data byte, and a registered copy of the condition it produced. The register file, memory and ALU beyond the compare stage are outside the block. The bench or the enclosing design models them.

Top module: `flagpred_seq`

## Requirements
- R1: A synchronous active-high reset, at any phase including the middle of a jump, sets `pc` to RESET_PC (default 0x0000), clears `wr_a`, `wr_b`, `wr_c`, `flag` and `wr_data`, and makes the next byte an opcode.
- R2: Condition codes, taken from bits 3:0 with A and B unsigned: 0 gives A==0; 1 gives A==B; 2 gives A>B; 3 gives A<B; 4 gives the carry out of bit 7 of A+B; codes 5 to 15 give 0. `flag` shows the code of the last opcode byte one cycle after that byte is taken. It holds during jump operand bytes. A single-byte instruction advances `pc` by 1.
- R3: Opcode 0x1 (compute) pulses `wr_c` for one cycle. The write data depends on the low nibble: codes 0 to 4 give the selected condition in bit 0 with the other bits 0; 8 gives A+B modulo 256; 9 gives A AND B; 10 gives A OR B; 11 gives A XOR B; every other code gives 0.
- R4: Opcode 0x2 (conditional move A to B) pulses `wr_b` with `wr_data`=A only when the selected condition is 1. Otherwise no strobe is raised and `wr_data` is 0.
- R5: Opcode 0x3 (move A to B) always pulses `wr_b` with `wr_data`=A.
- R6: Opcode 0x6 (condition to A) pulses `wr_a` with the selected condition in bit 0 of `wr_data` and 0 in the other bits.
- R7: Opcode 0x4 (conditional jump) reads the two following bytes as a target, low byte first. If the condition is 1, `pc` equals the target after the third byte. Otherwise `pc` equals the opcode address plus 3. The jump raises no write strobe.
- R8: The jump condition is sampled in the opcode cycle. Changes to A or B during the operand bytes do not change the outcome.
- R9: Opcode 0x5 (jump) loads the target regardless of the condition.
- R10: At most one write strobe is high in any cycle. Jump operand bytes are never decoded as instructions. Opcodes 0x0 and 0x7 to 0xF raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_byte | input | 8 | Byte read at address `pc` |
| reg_a | input | DATA_W | Current value of register A |
| reg_b | input | DATA_W | Current value of register B |
| pc | output | 16 | Program counter / fetch address |
| wr_a | output | 1 | Write strobe for register A |
| wr_b | output | 1 | Write strobe for register B |
| wr_c | output | 1 | Write strobe for register C (compute result) |
| wr_data | output | DATA_W | Data for the active write strobe, 0 when none |
| flag | output | 1 | Condition produced by the last opcode |

## Verification
The hardest situation to reach from the ports is a jump whose condition changes between the opcode byte and the operand bytes. It looks like the right outcome, but only because the condition was latched. The bench holds A and B so that the condition is false at the opcode. It then rewrites them during the operand cycles so that a late evaluation would take the jump. The bench also feeds operand bytes that would be move or compute instructions if decoded, and it applies reset in the middle of a jump. Together these show that the phase tracking, not the byte values, decides what is executed.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int INSN_W = 8;
  localparam int SEL_W  = INSN_W / 2;
  localparam int PC_W   = 2 * INSN_W;

  localparam logic [SEL_W-1:0] OP_NOP  = 4'h0;
  localparam logic [SEL_W-1:0] OP_ALU  = 4'h1;
  localparam logic [SEL_W-1:0] OP_CMOV = 4'h2;
  localparam logic [SEL_W-1:0] OP_MOV  = 4'h3;
  localparam logic [SEL_W-1:0] OP_JC   = 4'h4;
  localparam logic [SEL_W-1:0] OP_JMP  = 4'h5;
  localparam logic [SEL_W-1:0] OP_FLA  = 4'h6;

  localparam logic [SEL_W-1:0] CS_ZERO = 4'h0;
  localparam logic [SEL_W-1:0] CS_EQ   = 4'h1;
  localparam logic [SEL_W-1:0] CS_GT   = 4'h2;
  localparam logic [SEL_W-1:0] CS_LT   = 4'h3;
  localparam logic [SEL_W-1:0] CS_CARRY = 4'h4;
  localparam logic [SEL_W-1:0] AL_ADD  = 4'h8;
  localparam logic [SEL_W-1:0] AL_AND  = 4'h9;
  localparam logic [SEL_W-1:0] AL_OR   = 4'hA;
  localparam logic [SEL_W-1:0] AL_XOR  = 4'hB;

  typedef enum logic [1:0] {PH_OP, PH_LO, PH_HI} phase_e;
  typedef enum logic [1:0] {DS_NONE, DS_ALU, DS_A, DS_FLAG} dsel_e;
endpackage

// File: rtl/fp_cond_alu.sv
module fp_cond_alu
  import fp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SEL_W-1:0]  sel,
  output logic              cond,
  output logic [DATA_W-1:0] result
);
  localparam int SUM_W = DATA_W + 1;
  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, a} + {1'b0, b};

  always_comb begin
    case (sel)
      CS_ZERO:  cond = (a == '0);
      CS_EQ:    cond = (a == b);
      CS_GT:    cond = (a > b);
      CS_LT:    cond = (a < b);
      CS_CARRY: cond = sum[DATA_W];
      default:  cond = 1'b0;
    endcase
  end

  always_comb begin
    case (sel)
      CS_ZERO, CS_EQ, CS_GT, CS_LT, CS_CARRY:
                result = {{(DATA_W-1){1'b0}}, cond};
      AL_ADD:   result = sum[DATA_W-1:0];
      AL_AND:   result = a & b;
      AL_OR:    result = a | b;
      AL_XOR:   result = a ^ b;
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/fp_decode.sv
module fp_decode
  import fp_pkg::*;
(
  input  logic [SEL_W-1:0] opc,
  input  logic             cond,
  output logic             we_a,
  output logic             we_b,
  output logic             we_c,
  output logic             jump,
  output logic             jump_take,
  output dsel_e            dsel
);
  always_comb begin
    we_a      = 1'b0;
    we_b      = 1'b0;
    we_c      = 1'b0;
    jump      = 1'b0;
    jump_take = 1'b0;
    dsel      = DS_NONE;
    case (opc)
      OP_ALU:  begin we_c = 1'b1; dsel = DS_ALU; end
      OP_CMOV: begin we_b = cond; dsel = DS_A; end
      OP_MOV:  begin we_b = 1'b1; dsel = DS_A; end
      OP_JC:   begin jump = 1'b1; jump_take = cond; end
      OP_JMP:  begin jump = 1'b1; jump_take = 1'b1; end
      OP_FLA:  begin we_a = 1'b1; dsel = DS_FLAG; end
      default: ;
    endcase
  end
endmodule

// File: rtl/fp_pc_seq.sv
module fp_pc_seq
  import fp_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jump_start,
  input  logic              jump_take,
  input  logic [INSN_W-1:0] byte_in,
  output logic [PC_W-1:0]   pc,
  output phase_e            phase
);
  logic [INSN_W-1:0] tgt_lo;
  logic              take_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= RESET_PC;
      phase  <= PH_OP;
      tgt_lo <= '0;
      take_q <= 1'b0;
    end else begin
      case (phase)
        PH_OP: begin
          pc <= pc + PC_W'(1);
          if (jump_start) begin
            phase  <= PH_LO;
            take_q <= jump_take;
          end
        end
        PH_LO: begin
          tgt_lo <= byte_in;
          pc     <= pc + PC_W'(1);
          phase  <= PH_HI;
        end
        PH_HI: begin
          pc     <= take_q ? {byte_in, tgt_lo} : pc + PC_W'(1);
          take_q <= 1'b0;
          phase  <= PH_OP;
        end
        default: phase <= PH_OP;
      endcase
    end
  end
endmodule

// File: rtl/flagpred_seq.sv
module flagpred_seq
  import fp_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] code_byte,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  output logic [PC_W-1:0]   pc,
  output logic              wr_a,
  output logic              wr_b,
  output logic              wr_c,
  output logic [DATA_W-1:0] wr_data,
  output logic              flag
);
  logic [SEL_W-1:0]  opc;
  logic [SEL_W-1:0]  sel;
  logic              cond;
  logic [DATA_W-1:0] alu_res;
  logic              we_a, we_b, we_c, jump, jump_take;
  dsel_e             dsel;
  phase_e            phase;
  logic              in_op;
  logic [DATA_W-1:0] data_n;

  assign opc   = code_byte[INSN_W-1:SEL_W];
  assign sel   = code_byte[SEL_W-1:0];
  assign in_op = (phase == PH_OP);

  fp_cond_alu #(.DATA_W(DATA_W)) u_alu (
    .a(reg_a), .b(reg_b), .sel(sel), .cond(cond), .result(alu_res)
  );

  fp_decode u_dec (
    .opc(opc), .cond(cond), .we_a(we_a), .we_b(we_b), .we_c(we_c),
    .jump(jump), .jump_take(jump_take), .dsel(dsel)
  );

  fp_pc_seq #(.RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst(rst), .jump_start(in_op && jump), .jump_take(jump_take),
    .byte_in(code_byte), .pc(pc), .phase(phase)
  );

  always_comb begin
    case (dsel)
      DS_ALU:  data_n = alu_res;
      DS_A:    data_n = reg_a;
      DS_FLAG: data_n = {{(DATA_W-1){1'b0}}, cond};
      default: data_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_a    <= 1'b0;
      wr_b    <= 1'b0;
      wr_c    <= 1'b0;
      wr_data <= '0;
      flag    <= 1'b0;
    end else begin
      wr_a    <= in_op && we_a;
      wr_b    <= in_op && we_b;
      wr_c    <= in_op && we_c;
      wr_data <= (in_op && (we_a || we_b || we_c)) ? data_n : '0;
      if (in_op) flag <= cond;
    end
  end
endmodule

// File: rtl/flagpred_chk.sv
module flagpred_chk
  import fp_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [INSN_W-1:0] code_byte,
  input logic [DATA_W-1:0] reg_a,
  input logic [PC_W-1:0]   pc,
  input logic              wr_a,
  input logic              wr_b,
  input logic              wr_c,
  input logic [DATA_W-1:0] wr_data,
  input logic              flag
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc == RESET_PC && !wr_a && !wr_b && !wr_c && !flag && wr_data == '0));

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_a, wr_b, wr_c}));

  // R5
  move_data_chk: assert property (@(posedge clk) disable iff (rst)
    wr_b |-> (wr_data == $past(reg_a)));

  // R4
  cmov_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_b && $past(code_byte[INSN_W-1:SEL_W]) == OP_CMOV) |-> flag);

  // R6
  fla_format_chk: assert property (@(posedge clk) disable iff (rst)
    wr_a |-> (wr_data == {{(DATA_W-1){1'b0}}, flag}));

  // R3
  alu_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_c && $past(code_byte[SEL_W-1:0]) <= CS_CARRY) |->
      (wr_data == {{(DATA_W-1){1'b0}}, flag}));
endmodule

bind flagpred_seq flagpred_chk #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .code_byte(code_byte), .reg_a(reg_a), .pc(pc),
  .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_data(wr_data), .flag(flag)
);

// File: tb/flagpred_seq_bench.sv
`timescale 1ns/1ps
module flagpred_seq_bench;
  localparam int DW = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]    code_byte = '0;
  logic [DW-1:0] reg_a = '0, reg_b = '0;
  logic [AW-1:0] pc;
  logic          wr_a, wr_b, wr_c, flag;
  logic [DW-1:0] wr_data;
  int            checks = 0, fails = 0;
  logic [AW-1:0] exp_pc;

  always #2 clk = ~clk;

  flagpred_seq #(.DATA_W(DW)) u_flagpred_seq (
    .clk(clk), .rst(rst), .code_byte(code_byte), .reg_a(reg_a), .reg_b(reg_b),
    .pc(pc), .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_data(wr_data), .flag(flag)
  );

  typedef struct packed {
    logic [7:0] op; logic [7:0] a; logic [7:0] b;
    logic fl; logic wa; logic wb; logic wc; logic [7:0] wd;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [0:NV-1] = '{
    '{8'h10, 8'h00, 8'h05, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01},
    '{8'h10, 8'h03, 8'h05, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00},
    '{8'h11, 8'h07, 8'h07, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01},
    '{8'h12, 8'hC8, 8'h64, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01},
    '{8'h13, 8'hC8, 8'h64, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00},
    '{8'h14, 8'hC8, 8'h64, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01},
    '{8'h14, 8'h64, 8'h9B, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00},
    '{8'h18, 8'hC8, 8'h64, 1'b0, 1'b0, 1'b0, 1'b1, 8'h2C},
    '{8'h19, 8'hF0, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 8'h30},
    '{8'h1B, 8'hF0, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 8'hCC},
    '{8'h21, 8'h09, 8'h09, 1'b1, 1'b0, 1'b1, 1'b0, 8'h09},
    '{8'h21, 8'h09, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'h25, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'h32, 8'h01, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01},
    '{8'h63, 8'h01, 8'h02, 1'b1, 1'b1, 1'b0, 1'b0, 8'h01},
    '{8'h00, 8'h00, 8'h07, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'hF4, 8'hFF, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'h1F, 8'h11, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] b8, input logic [7:0] av, input logic [7:0] bv);
    code_byte = b8; reg_a = av; reg_b = bv;
    @(negedge clk);
  endtask

  task automatic no_writes(input string req);
    chk(req, "strobes", {wr_a, wr_b, wr_c}, 3'b000);
  endtask

  function automatic string req_of(input logic [7:0] op);
    case (op[7:4])
      4'h1: return "R3";
      4'h2: return "R4";
      4'h3: return "R5";
      4'h6: return "R6";
      default: return "R10";
    endcase
  endfunction

  // three-byte jump; expects pc after operands
  task automatic jump3(input string req, input logic [7:0] op,
                       input logic [7:0] a0, input logic [7:0] b0,
                       input logic [7:0] a1, input logic [7:0] b1,
                       input logic [7:0] lo, input logic [7:0] hi,
                       input logic taken);
    logic [AW-1:0] start;
    start = exp_pc;
    step(op, a0, b0);
    no_writes(req);
    chk(req, "pc after jump opcode", pc, start + 16'd1);
    step(lo, a1, b1);
    no_writes("R10");
    step(hi, a1, b1);
    no_writes("R10");
    exp_pc = taken ? {hi, lo} : start + 16'd3;
    chk(req, "pc after jump", pc, exp_pc);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pc", pc, 16'h0000);
    chk("R1", "strobes", {wr_a, wr_b, wr_c}, 3'b000);
    chk("R1", "flag", flag, 1'b0);
    chk("R1", "wr_data", wr_data, 8'h00);
    rst = 1'b0;
    exp_pc = '0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].op, VEC[i].a, VEC[i].b);
      exp_pc = exp_pc + 16'd1;
      chk("R2", "pc", pc, exp_pc);
      chk("R2", "flag", flag, VEC[i].fl);
      chk(req_of(VEC[i].op), "wr_a", wr_a, VEC[i].wa);
      chk(req_of(VEC[i].op), "wr_b", wr_b, VEC[i].wb);
      chk(req_of(VEC[i].op), "wr_c", wr_c, VEC[i].wc);
      chk(req_of(VEC[i].op), "wr_data", wr_data, VEC[i].wd);
    end

    // R7 taken (A==B); operand bytes look like MOV and compute opcodes
    jump3("R7", 8'h41, 8'h05, 8'h05, 8'h06, 8'h05, 8'h34, 8'h12, 1'b1);
    chk("R2", "flag held", flag, 1'b1);
    // R7 not taken (A>B false)
    jump3("R7", 8'h42, 8'h01, 8'h05, 8'h01, 8'h05, 8'h21, 8'h30, 1'b0);
    // R8 false at opcode, true during operands
    jump3("R8", 8'h43, 8'h09, 8'h03, 8'h01, 8'h03, 8'h78, 8'h56, 1'b0);
    // R8 true at opcode, false during operands
    jump3("R8", 8'h44, 8'hC8, 8'h64, 8'h01, 8'h01, 8'h00, 8'h80, 1'b1);
    // R2 unused condition code suppresses jump
    jump3("R2", 8'h47, 8'h00, 8'h00, 8'h00, 8'h00, 8'h11, 8'h22, 1'b0);
    // R9 unconditional jump with a false condition
    jump3("R9", 8'h55, 8'h00, 8'h00, 8'h00, 8'h00, 8'hCD, 8'hAB, 1'b1);

    // R1 reset in the middle of a jump
    step(8'h50, 8'h00, 8'h00);
    rst = 1'b1;
    step(8'h3F, 8'h00, 8'h00);
    chk("R1", "pc mid-jump", pc, 16'h0000);
    chk("R1", "strobes mid-jump", {wr_a, wr_b, wr_c}, 3'b000);
    rst = 1'b0;
    step(8'h30, 8'h5A, 8'h00);
    chk("R1", "opcode after reset", wr_b, 1'b1);
    chk("R1", "data after reset", wr_data, 8'h5A);
    chk("R1", "pc after reset", pc, 16'h0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule